// File: doc/BRIEF.md
# Millisecond Tick Counter with Compare Event

This peripheral keeps an 8-bit time base that steps once every millisecond. A prescaler counts system clock cycles and produces a single-cycle tick at a rate of 1 kHz. The tick advances a free-running counter, which rolls over from 255 to 0 without stopping. Software reaches the counter and a compare value through a small word-addressed register bus. It can read both registers at any time and overwrite either one.

When a tick moves the counter onto the compare value, the block emits a one-cycle event on its interrupt line. An interrupt controller elsewhere latches that pulse, so this block holds no pending state. A match event does not reload or clear the counter. The counter keeps running, and the next event comes only when a later tick brings the counter back onto the compare value.

Top module: `ms_timer`

## Requirements
- R1: After reset the counter reads 0, the compare value reads 0 and the interrupt output is low.
- R2: With no software write, the counter rises by exactly 1 every CLK_HZ/1000 clock cycles and stays unchanged between ticks.
- R3: The counter rolls over from 255 to 0 on a tick. If the compare value is 0, that rollover raises an event.
- R4: The counter is written and read at byte address 0x08. Bits 7:0 of the write data load it, and the bits above 7 read as zero.
- R5: The compare value is written and read at byte address 0x0C. Bits 7:0 are stored, and the bits above 7 read as zero.
- R6: When a counter write and a tick fall on the same clock edge, the written value is loaded and the tick is lost.
- R7: The interrupt output is high for exactly one cycle. That cycle is the first one in which the counter holds a value equal to the compare value as a result of a tick.
- R8: No event is raised while the counter holds between ticks. No event is raised when software writes a counter value equal to the compare value.
- R9: Reads from any other address return zero, and writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when no read is requested |
| irq_pulse | output | 1 | One-cycle match event toward the interrupt controller |

## Verification
The counter is observed in three ways: left to run across several ticks, loaded by a write that lands between ticks, and loaded by a write placed on the exact edge of a tick. Comparing these separates correct increments from a lost or doubled step, and shows which source wins a same-edge conflict. The event line is tested in four situations: a match reached by ticks, a match at rollover, a match created by a direct counter write, and the idle cycles after a match. Together these confirm that only a tick can start an event and that the event never stretches or repeats. Accesses to an unmapped address and writes with non-zero upper bits show that stray traffic is ignored and that only the low byte is kept.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CMP  = 2'd2
    } tm_sel_e;
endpackage

// File: rtl/tm_prescaler.sv
module tm_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pre == LAST) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.pre == LAST);
endmodule

// File: rtl/tm_compare.sv
module tm_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cmp_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cmp = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o = st_q.cmp;
endmodule

// File: rtl/tm_counter.sv
module tm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        step     = st_q.cnt + 1'b1;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i) begin
            st_d.cnt = step;
            st_d.irq = (step == cmp_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/ms_timer.sv
module ms_timer #(
    parameter int              CLK_HZ  = 50_000_000,
    parameter int              TICK_HZ = 1000,
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 32,
    parameter int              CNT_W   = 8,
    parameter logic [ADDR_W-1:0] CNT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] CMP_OFS = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse
);
    import tm_pkg::*;

    localparam int DIV = CLK_HZ / TICK_HZ;

    tm_sel_e          sel;
    logic             tick;
    logic             cnt_wr;
    logic             cmp_wr;
    logic [CNT_W-1:0] wbyte;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_val;
    logic             unused_wdata;

    always_comb begin
        if (bus_addr == CNT_OFS) begin
            sel = SEL_CNT;
        end else if (bus_addr == CMP_OFS) begin
            sel = SEL_CMP;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign cnt_wr       = bus_wr && (sel == SEL_CNT);
    assign cmp_wr       = bus_wr && (sel == SEL_CMP);
    assign wbyte        = bus_wdata[CNT_W-1:0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    tm_prescaler #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cmp_wr),
        .wdata_i (wbyte),
        .cmp_o   (cmp_val)
    );

    tm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_i    (cnt_wr),
        .wdata_i (wbyte),
        .cmp_i   (cmp_val),
        .cnt_o   (cnt_val),
        .irq_o   (irq_pulse)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CNT: bus_rdata[CNT_W-1:0] = cnt_val;
                SEL_CMP: bus_rdata[CNT_W-1:0] = cmp_val;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tm_chk.sv
module tm_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cnt_wr,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] wbyte,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             irq
);
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == $past(cmp)));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(tick) && !$past(cnt_wr)));

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wbyte)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(cnt_wr)) |-> $stable(cnt));

    // R5
    cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> (cmp == $past(wbyte)));
endmodule

bind ms_timer tm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt_wr (cnt_wr),
    .cmp_wr (cmp_wr),
    .wbyte  (wbyte),
    .cnt    (cnt_val),
    .cmp    (cmp_val),
    .irq    (irq_pulse)
);

// File: tb/sim_ms_timer.sv
`timescale 1ns/1ps
module sim_ms_timer;
    localparam int CLK_HZ = 8000;
    localparam int DIV    = CLK_HZ / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    always #4 clk = ~clk;

    ms_timer #(.CLK_HZ(CLK_HZ)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    typedef struct {
        logic [7:0]  addr;
        bit          fixed;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    int n_cmp = 0;
    int n_bad = 0;
    int irq_seen = 0;
    logic [31:0] last_rd = '0;
    bit done = 1'b0;

    // requirement-level reference state
    int         m_pre = 0;
    logic [7:0] m_cnt = '0;
    logic [7:0] m_cmp = '0;
    logic       m_irq = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h08) return {24'd0, m_cnt};
        if (a == 8'h0C) return {24'd0, m_cmp};
        return 32'd0;
    endfunction

    // monitor: compares at the falling edge, then advances the reference
    always @(negedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = '0; m_cmp = '0; m_irq = 1'b0;
        end else begin
            if (bus_rd) begin
                item_t it;
                logic [31:0] e;
                if (sb.size() == 0) begin
                    check("SB", 32'hBAD, 32'h0);
                end else begin
                    it = sb.pop_front();
                    e = it.fixed ? it.exp : model_read(it.addr);
                    check(it.req, bus_rdata, e);
                    last_rd = bus_rdata;
                end
            end
            check("R7 irq", {31'd0, irq_pulse}, {31'd0, m_irq});
            if (irq_pulse) irq_seen++;
            begin
                bit t, cw, mw;
                t  = (m_pre == DIV - 1);
                cw = bus_wr && (bus_addr == 8'h08);
                mw = bus_wr && (bus_addr == 8'h0C);
                m_pre = t ? 0 : m_pre + 1;
                m_irq = 1'b0;
                if (cw) begin
                    m_cnt = bus_wdata[7:0];
                end else if (t) begin
                    m_cnt = m_cnt + 8'd1;
                    m_irq = (m_cnt == m_cmp);
                end
                if (mw) m_cmp = bus_wdata[7:0];
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input string req,
                           input bit fixed, input logic [31:0] exp);
        item_t it;
        @(posedge clk); #2;
        it.addr = a; it.fixed = fixed; it.exp = exp; it.req = req;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        logic [31:0] r1;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset values
        do_read(8'h08, "R1 cnt", 1'b1, 32'd0);
        do_read(8'h0C, "R1 cmp", 1'b1, 32'd0);

        // R2 free running count
        idle(40);
        do_read(8'h08, "R2 run", 1'b0, 0);
        r1 = last_rd;
        idle(30);
        do_read(8'h08, "R2 run", 1'b0, 0);
        check("R2 rate", (last_rd - r1) & 32'hFF, 32'd4);

        // R4 counter write keeps low byte
        do_write(8'h08, 32'h1234_56AB);
        do_read(8'h08, "R4 cnt", 1'b1, 32'h0000_00AB);

        // R5 compare write keeps low byte
        do_write(8'h0C, 32'hDEAD_BEC7);
        do_read(8'h0C, "R5 cmp", 1'b1, 32'h0000_00C7);

        // R9 unmapped address
        do_write(8'h10, 32'hFFFF_FFFF);
        do_read(8'h10, "R9 none", 1'b1, 32'd0);
        do_read(8'h0C, "R9 cmp", 1'b1, 32'h0000_00C7);
        do_read(8'h08, "R9 cnt", 1'b0, 0);

        // R6 write on the tick edge
        do @(posedge clk); while (m_pre != DIV - 1);
        #2;
        bus_addr = 8'h08; bus_wdata = 32'h40; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
        do_read(8'h08, "R6 prio", 1'b1, 32'h40);

        // R7 match by ticks, single pulse, none while holding
        do_write(8'h0C, 32'h45);
        do_write(8'h08, 32'h43);
        base = irq_seen;
        idle(40);
        check("R7 count", irq_seen - base, 32'd1);

        // R8 software write equal to compare raises nothing
        do_write(8'h0C, 32'h80);
        base = irq_seen;
        do_write(8'h08, 32'h80);
        idle(5);
        check("R8 swmatch", irq_seen - base, 32'd0);
        do_read(8'h08, "R8 cnt", 1'b0, 0);

        // R3 rollover and match at zero
        do_write(8'h0C, 32'h00);
        do_write(8'h08, 32'hFE);
        base = irq_seen;
        idle(24);
        do_read(8'h08, "R3 wrap", 1'b0, 0);
        check("R3 wrapirq", irq_seen - base, 32'd1);
        check("R3 small", {31'd0, (last_rd < 32'd4)}, 32'd1);

        idle(4);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule